// File: doc/BRIEF.md
# Half-Warp Memory Request Coalescer

This block receives one batch of load requests from sixteen parallel lanes (half of a 32-thread warp) and reduces it to as few size-aligned memory transactions as it can. Each lane presents an active bit and a byte address. All lanes share one element size. A mode input picks the rule that is applied. Under the strict rule the whole batch merges into one transaction only when it forms a perfectly ordered, aligned block; otherwise every active lane is served on its own. The relaxed rule accepts any lane-to-element order and greedily covers the batch with 32, 64 and 128 byte segments, shrinking each segment while only one half of it is used.

A batch is taken over a valid/ready handshake. The transactions leave one per cycle over a second valid/ready handshake, so the memory side can stall the block. Each transaction carries its base address, a size code and the mask of lanes it serves. A done flag marks the last transaction of the batch. The next batch is not taken until that last transaction has been handed off.

Top module: `hwc_coalescer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` and `out_done` are 0.
- R2: `out_size` encodes 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes, and never takes the value 3. `out_base` is always a multiple of the transaction size. `in_esize` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R3: Strict mode merges a batch when two conditions hold. First, the block start, taken as the lowest active lane's address minus lane index times element size, is a multiple of 16 times the element size. Second, every active lane k addresses block start plus k times element size. The batch then leaves as one transaction of max(32, 16 × element size) bytes whose lane mask equals the active mask.
- R4: In strict mode, if any condition of R3 fails, each active lane gets its own 32-byte transaction covering its address, issued in ascending lane order.
- R5: In relaxed mode the lowest pending lane selects the aligned segment holding its address. The segment is 32 bytes for 1-byte elements, 64 bytes for 2-byte elements and 128 bytes for 4 and 8 byte elements. Every pending lane inside that segment joins the transaction. Lane order does not matter.
- R6: In relaxed mode a segment is halved, repeatedly and down to 32 bytes, while all of its gathered lanes fall in one half.
- R7: In relaxed mode a contiguous, misaligned run of sixteen elements is served by one transaction, or by two when it crosses a segment boundary.
- R8: Across one batch the lane masks are disjoint and non-empty, their union equals the active mask, and each lane's address lies inside the transaction that serves it.
- R9: While `out_valid` is 1 and `out_ready` is 0, the offered transaction stays unchanged.
- R10: `in_ready` is 0 from batch acceptance until the transaction flagged by `out_done` is accepted. The flag is set on the last transaction only, and `in_ready` returns the next cycle.
- R11: A batch with no active lanes produces no transaction. `out_done` is then 1 for exactly the cycle after acceptance, with `out_valid` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Batch offered |
| in_ready | output | 1 | Block can take a batch |
| in_mask | input | LANES | Active bit per lane |
| in_addr | input | LANES*AW | Byte address per lane, lane k at bits k*AW upward |
| in_esize | input | 2 | Element size code (R2) |
| in_strict | input | 1 | 1 selects the strict rule, 0 the relaxed rule |
| out_valid | output | 1 | Transaction offered |
| out_ready | input | 1 | Memory side takes the transaction |
| out_base | output | AW | Aligned base byte address |
| out_size | output | 2 | Size code (R2) |
| out_lanes | output | LANES | Lanes served by this transaction |
| out_done | output | 1 | Last transaction of batch, or empty-batch marker |

## Verification
The bound checker checks these on every cycle: size codes are legal and bases aligned, a stalled transaction holds steady, no batch is taken while one is pending, lane masks are non-empty, an empty-batch done only follows an acceptance, and the block is ready again after the final handshake. Which transactions a given address pattern produces can only be shown by the directed scenarios. This covers strict merging against fallback, permuted, offset, strided and segment-crossing relaxed patterns, segment shrinking, and the exact count and lane union per batch. The bench checks those results against counts and bases worked out by hand from the requirements.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [1:0] {
      SZ32  = 2'd0,
      SZ64  = 2'd1,
      SZ128 = 2'd2
   } txn_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EMIT  = 2'd1,
      ST_EMPTY = 2'd2
   } state_e;

   // starting segment for relaxed gathering, by element size code
   function automatic logic [1:0] start_seg(input logic [1:0] es);
      case (es)
         2'd0:    return SZ32;
         2'd1:    return SZ64;
         default: return SZ128;
      endcase
   endfunction

   // transaction size for a merged strict batch: max(32, 16*element)
   function automatic logic [1:0] strict_seg(input logic [1:0] es);
      return (es == 2'd0) ? 2'd0 : es - 2'd1;
   endfunction

endpackage

// File: rtl/hwc_first_lane.sv
module hwc_first_lane #(
   parameter int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/hwc_strict_check.sv
module hwc_strict_check #(
   parameter int LANES = 16,
   parameter int AW    = 32,
   localparam int LW   = $clog2(LANES)
) (
   input  logic [LANES-1:0]    mask,
   input  logic [LANES*AW-1:0] addr,
   input  logic [1:0]          esize,
   output logic                ok
);
   logic [LW-1:0] lead;
   logic [AW-1:0] blk;
   logic [AW-1:0] blk_span;

   hwc_first_lane #(.N(LANES)) u_first (.req(mask), .idx(lead));

   always_comb begin
      blk      = addr[lead*AW +: AW] - (AW'(lead) << esize);
      blk_span = AW'(LANES) << esize;
      ok       = ((blk & (blk_span - AW'(1))) == '0);
      for (int k = 0; k < LANES; k++) begin
         if (mask[k] && (addr[k*AW +: AW] != blk + (AW'(k) << esize)))
            ok = 1'b0;
      end
   end
endmodule

// File: rtl/hwc_segment.sv
module hwc_segment #(
   parameter int LANES = 16,
   parameter int AW    = 32,
   localparam int LW   = $clog2(LANES)
) (
   input  logic [LANES-1:0]    pend,
   input  logic [LANES*AW-1:0] addr,
   input  logic [1:0]          esize,
   input  logic [LW-1:0]       lead,
   output logic [AW-1:0]       base,
   output logic [1:0]          size,
   output logic [LANES-1:0]    lanes
);
   import hwc_pkg::*;

   logic [AW-1:0] a [LANES];
   logic [AW-1:0] keep;
   logic          hi_any, lo_any;

   for (genvar k = 0; k < LANES; k++) begin : g_unpack
      assign a[k] = addr[k*AW +: AW];
   end

   always_comb begin
      size  = start_seg(esize);
      keep  = ~((AW'(32) << size) - AW'(1));
      base  = a[lead] & keep;
      for (int k = 0; k < LANES; k++)
         lanes[k] = pend[k] && ((a[k] & keep) == base);
      // halve while only one half holds gathered lanes
      for (int step = 2; step >= 1; step--) begin
         hi_any = 1'b0;
         lo_any = 1'b0;
         if (size == 2'(step)) begin
            for (int k = 0; k < LANES; k++) begin
               if (lanes[k] &&  a[k][step+4]) hi_any = 1'b1;
               if (lanes[k] && !a[k][step+4]) lo_any = 1'b1;
            end
            if (!(hi_any && lo_any)) begin
               size = 2'(step - 1);
               if (hi_any) base = base | (AW'(1) << (step + 4));
            end
         end
      end
   end
endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer #(
   parameter int LANES      = 16,
   parameter int AW         = 32,
   parameter bit HAS_STRICT = 1'b1,
   localparam int LW        = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [LANES-1:0]    in_mask,
   input  logic [LANES*AW-1:0] in_addr,
   input  logic [1:0]          in_esize,
   input  logic                in_strict,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [AW-1:0]       out_base,
   output logic [1:0]          out_size,
   output logic [LANES-1:0]    out_lanes,
   output logic                out_done
);
   import hwc_pkg::*;

   if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8 to hold a 128-byte offset");
   end

   state_e              state_q;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES-1:0]    pend_q;
   logic [1:0]          es_q;
   logic                strict_q, merge_q;
   logic                merge_in;
   logic [LW-1:0]       lead;
   logic [AW-1:0]       lead_addr, blk_start;
   logic [1:0]          merge_sz;
   logic [AW-1:0]       rel_base;
   logic [1:0]          rel_size;
   logic [LANES-1:0]    rel_lanes;
   logic [LANES-1:0]    left;

   if (HAS_STRICT) begin : g_strict
      hwc_strict_check #(.LANES(LANES), .AW(AW)) u_check (
         .mask(in_mask), .addr(in_addr), .esize(in_esize), .ok(merge_in)
      );
   end else begin : g_no_strict
      assign merge_in = 1'b0;
   end

   hwc_first_lane #(.N(LANES)) u_lead (.req(pend_q), .idx(lead));

   hwc_segment #(.LANES(LANES), .AW(AW)) u_seg (
      .pend(pend_q), .addr(addr_q), .esize(es_q), .lead(lead),
      .base(rel_base), .size(rel_size), .lanes(rel_lanes)
   );

   assign lead_addr = addr_q[lead*AW +: AW];
   assign blk_start = lead_addr - (AW'(lead) << es_q);
   assign merge_sz  = strict_seg(es_q);

   always_comb begin
      if (!strict_q) begin
         out_base  = rel_base;
         out_size  = rel_size;
         out_lanes = rel_lanes;
      end else if (merge_q) begin
         out_base  = blk_start & ~((AW'(32) << merge_sz) - AW'(1));
         out_size  = merge_sz;
         out_lanes = pend_q;
      end else begin
         out_base  = lead_addr & ~AW'(31);
         out_size  = SZ32;
         out_lanes = LANES'(1) << lead;
      end
   end

   assign left      = pend_q & ~out_lanes;
   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_EMIT);
   assign out_done  = (state_q == ST_EMPTY) || (out_valid && (left == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         pend_q   <= '0;
         es_q     <= '0;
         strict_q <= 1'b0;
         merge_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (in_valid) begin
               addr_q   <= in_addr;
               pend_q   <= in_mask;
               es_q     <= in_esize;
               strict_q <= HAS_STRICT && in_strict;
               merge_q  <= merge_in;
               state_q  <= (in_mask != '0) ? ST_EMIT : ST_EMPTY;
            end
            ST_EMIT: if (out_ready) begin
               pend_q <= left;
               if (left == '0) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
   parameter int LANES = 16,
   parameter int AW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [AW-1:0]    out_base,
   input logic [1:0]       out_size,
   input logic [LANES-1:0] out_lanes,
   input logic             out_done
);
   p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_size != 2'd3);

   p_base_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_base & ((AW'(32) << out_size) - AW'(1))) == '0);

   p_lanes_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_lanes != '0);

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_base)
         && $stable(out_size) && $stable(out_lanes));

   p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_ready_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_done |=> in_ready);

   p_empty_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_done && !out_valid |-> $past(in_valid && in_ready) && !in_ready);
endmodule

bind hwc_coalescer hwc_checker #(.LANES(LANES), .AW(AW)) u_hwc_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
   .out_size(out_size), .out_lanes(out_lanes), .out_done(out_done)
);

// File: tb/tb_hwc_coalescer.sv
module tb_hwc_coalescer;
   localparam int L = 16;
   localparam int W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [L-1:0]    in_mask = '0;
   logic [L*W-1:0]  in_addr = '0;
   logic [1:0]      in_esize = '0;
   logic            in_strict = 1'b0;
   logic            out_valid;
   logic            out_ready = 1'b1;
   logic [W-1:0]    out_base;
   logic [1:0]      out_size;
   logic [L-1:0]    out_lanes;
   logic            out_done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [W-1:0] a [L];
   logic [W-1:0] tb_base [32];
   logic [1:0]   tb_size [32];
   logic [L-1:0] tb_lanes [32];
   int           tb_n;
   bit           tb_empty_done;

   always #5 clk = ~clk;

   hwc_coalescer #(.LANES(L), .AW(W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_mask(in_mask), .in_addr(in_addr), .in_esize(in_esize),
      .in_strict(in_strict), .out_valid(out_valid), .out_ready(out_ready),
      .out_base(out_base), .out_size(out_size), .out_lanes(out_lanes),
      .out_done(out_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [W-1:0] start, input int step);
      for (int k = 0; k < L; k++) a[k] = start + W'(k * step);
   endtask

   task automatic offer(input logic [L-1:0] m, input logic [1:0] es, input bit st);
      @(negedge clk);
      for (int k = 0; k < L; k++) in_addr[k*W +: W] = a[k];
      in_mask = m; in_esize = es; in_strict = st; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // runs one batch, checks R8 on every transaction, count and union at end
   task automatic run_batch(input string tag, input logic [L-1:0] m,
                            input logic [1:0] es, input bit st, input int exp_n);
      logic [L-1:0] seen = '0;
      bit done = 1'b0;
      tb_n = 0; tb_empty_done = 1'b0;
      offer(m, es, st);
      for (int it = 0; it < 40 && !done; it++) begin
         if (out_valid) begin
            tb_base[tb_n] = out_base; tb_size[tb_n] = out_size;
            tb_lanes[tb_n] = out_lanes; tb_n++;
            chk((out_lanes & seen) == '0 && (out_lanes & ~m) == '0, "R8",
                {tag, " lanes disjoint and active"}, out_lanes, m & ~seen);
            for (int k = 0; k < L; k++) begin
               if (out_lanes[k])
                  chk(a[k] >= out_base && a[k] < out_base + (W'(32) << out_size),
                      "R8", {tag, " lane address inside transaction"}, a[k], out_base);
            end
            seen |= out_lanes;
            if (out_done) done = 1'b1;
            else chk(in_ready == 1'b0, "R10", {tag, " busy while pending"}, in_ready, 0);
         end else if (out_done) begin
            tb_empty_done = 1'b1; done = 1'b1;
         end
         @(negedge clk);
      end
      chk(tb_n == exp_n, "R8", {tag, " transaction count"}, tb_n, exp_n);
      chk(seen == m, "R8", {tag, " lane union"}, seen, m);
      chk(in_ready == 1'b1 && out_done == 1'b0, "R10", {tag, " ready after last"},
          in_ready, 1);
   endtask

   task automatic chk_tx(input string req, input string tag, input int i,
                         input logic [W-1:0] b, input logic [1:0] s,
                         input logic [L-1:0] ln);
      chk(tb_base[i] == b, req, {tag, " base"}, tb_base[i], b);
      chk(tb_size[i] == s, req, {tag, " size"}, tb_size[i], s);
      chk(tb_lanes[i] == ln, req, {tag, " lanes"}, tb_lanes[i], ln);
   endtask

   task automatic t_reset;
      chk(in_ready == 1'b1 && out_valid == 1'b0 && out_done == 1'b0, "R1",
          "reset state", {in_ready, out_valid, out_done}, 3'b100);
   endtask

   task automatic t_strict_aligned;
      fill(32'h1000, 4);
      run_batch("strict aligned 4B", 16'hFFFF, 2'd2, 1'b1, 1);
      chk_tx("R3", "strict aligned 4B", 0, 32'h1000, 2'd1, 16'hFFFF);
      fill(32'h7010, 1);
      run_batch("strict aligned 1B", 16'hFFFF, 2'd0, 1'b1, 1);
      chk_tx("R3", "strict aligned 1B", 0, 32'h7000, 2'd0, 16'hFFFF);
   endtask

   task automatic t_strict_sparse;
      fill(32'h1000, 4);
      run_batch("strict sparse", 16'h0F0E, 2'd2, 1'b1, 1);
      chk_tx("R3", "strict sparse", 0, 32'h1000, 2'd1, 16'h0F0E);
   endtask

   task automatic t_strict_fallback;
      fill(32'h1004, 4);
      run_batch("strict misaligned", 16'hFFFF, 2'd2, 1'b1, 16);
      chk_tx("R4", "strict misaligned first", 0, 32'h1000, 2'd0, 16'h0001);
      chk_tx("R4", "strict misaligned last", 15, 32'h1040, 2'd0, 16'h8000);
      fill(32'h1000, 4);
      a[0] = 32'h1004; a[1] = 32'h1000;
      run_batch("strict permuted", 16'hFFFF, 2'd2, 1'b1, 16);
      chk_tx("R4", "strict permuted second", 1, 32'h1000, 2'd0, 16'h0002);
   endtask

   task automatic t_relaxed_gather;
      fill(32'h2000, 4);
      a[0] = 32'h2004; a[1] = 32'h2000;
      run_batch("relaxed permuted", 16'hFFFF, 2'd2, 1'b0, 1);
      chk_tx("R5", "relaxed permuted", 0, 32'h2000, 2'd1, 16'hFFFF);
      for (int k = 0; k < L; k++) a[k] = 32'h400F - W'(k);
      run_batch("relaxed reversed 1B", 16'hFFFF, 2'd0, 1'b0, 1);
      chk_tx("R5", "relaxed reversed 1B", 0, 32'h4000, 2'd0, 16'hFFFF);
      fill(32'h5000, 8);
      run_batch("relaxed 8B", 16'hFFFF, 2'd3, 1'b0, 1);
      chk_tx("R5", "relaxed 8B", 0, 32'h5000, 2'd2, 16'hFFFF);
      fill(32'h3000, 128);
      run_batch("relaxed stride", 16'hFFFF, 2'd2, 1'b0, 16);
      chk_tx("R5", "relaxed stride first", 0, 32'h3000, 2'd0, 16'h0001);
   endtask

   task automatic t_relaxed_shrink;
      fill(32'h6000, 2);
      run_batch("relaxed shrink 2B", 16'hFFFF, 2'd1, 1'b0, 1);
      chk_tx("R6", "relaxed shrink 2B", 0, 32'h6000, 2'd0, 16'hFFFF);
      fill(32'h2060, 4);
      run_batch("relaxed shrink upper", 16'hFFFF, 2'd2, 1'b0, 2);
      chk_tx("R6", "relaxed shrink upper", 0, 32'h2060, 2'd0, 16'h00FF);
   endtask

   task automatic t_relaxed_offset;
      fill(32'h2004, 4);
      run_batch("relaxed offset", 16'hFFFF, 2'd2, 1'b0, 1);
      chk_tx("R7", "relaxed offset", 0, 32'h2000, 2'd2, 16'hFFFF);
      fill(32'h2060, 4);
      run_batch("relaxed crossing", 16'hFFFF, 2'd2, 1'b0, 2);
      chk_tx("R7", "relaxed crossing second", 1, 32'h2080, 2'd0, 16'hFF00);
   endtask

   task automatic t_empty;
      fill(32'h1000, 4);
      run_batch("empty batch", 16'h0000, 2'd2, 1'b0, 0);
      chk(tb_empty_done == 1'b1, "R11", "empty batch done pulse", tb_empty_done, 1);
   endtask

   task automatic t_backpressure;
      logic [W-1:0] b0;
      logic [L-1:0] l0;
      int cnt = 0;
      bit done = 1'b0;
      fill(32'h1004, 4);
      out_ready = 1'b0;
      offer(16'hFFFF, 2'd2, 1'b1);
      b0 = out_base; l0 = out_lanes;
      chk(out_valid == 1'b1, "R9", "valid under stall", out_valid, 1);
      // a second batch offered while busy must not be taken
      fill(32'h9000, 4);
      for (int k = 0; k < L; k++) in_addr[k*W +: W] = a[k];
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_base == b0 && out_lanes == l0, "R9", "stalled transaction held",
          out_base, b0);
      chk(in_ready == 1'b0, "R10", "no accept while busy", in_ready, 0);
      in_valid = 1'b0;
      out_ready = 1'b1;
      for (int it = 0; it < 40 && !done; it++) begin
         if (out_valid) begin
            cnt++;
            if (out_done) done = 1'b1;
         end
         @(negedge clk);
      end
      chk(cnt == 16, "R10", "first batch drained intact", cnt, 16);
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after drain",
          in_ready, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_strict_aligned();
      t_strict_sparse();
      t_strict_fallback();
      t_relaxed_gather();
      t_relaxed_shrink();
      t_relaxed_offset();
      t_empty();
      t_backpressure();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule